// File: doc/BRIEF.md
# Zero-Pair Triggered Window Detector

This block watches a serial bit stream, one symbol per clock, and raises a single-bit flag when a pair of back-to-back 0 symbols is followed by a three-symbol window holding at least one 1. The flag is a Mealy output. It is valid during the cycle that carries the third window symbol, so a 1 arriving on that symbol raises the flag in the same cycle.

Each window is evaluated exactly once. When it closes, the detector drops back to its search state whatever the result, and it must then collect a fresh pair of 0s. Zeros that fell inside the window are not carried over toward the next trigger. While it is still searching, any 1 discards partial pair progress. A synchronous active-high reset returns the detector to the search state with no zeros counted.

Top module: `zp_window_det`

## Requirements
- R1: While `rst` is high at a clock edge, the detector returns to the search state with no zeros counted. `hit` is 0 from the cycle after that edge until a complete trigger pair and window have been seen.
- R2: `hit` is 1 only in a cycle whose two preceding-window symbols (the 4th and 3rd symbols before the current one) were both 0 and that formed a trigger pair. At least one of the current symbol and the two symbols before it must be 1.
- R3: When the first two window symbols are 0, `hit` follows the current input combinationally in the third window cycle. It is 1 in the same cycle that `din` is 1.
- R4: A 1 on the first or second window symbol is remembered. `hit` is 1 on the third window symbol even if that symbol is 0, and `hit` stays 0 on the first and second window symbols.
- R5: A window of three 0 symbols gives `hit` = 0 on all three symbols.
- R6: After the third window symbol, the detector is searching again. Zeros inside the window do not count toward a new pair, so `hit` is never 1 in two consecutive cycles and needs two new 0s after the window.
- R7: While searching, a 1 input clears a single counted zero. The sequence 0,1,0 followed by a window does not trigger.
- R8: For the input stream 0100010010010010000000011 applied from the search state, `hit` is 0000001000000100000000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial input symbol sampled each clock |
| hit | output | 1 | Mealy flag, 1 on the third window symbol when the window held a 1 |

## Verification
Directed streams place the single 1 of a window on each of its three positions. This separates the combinational path (R3) from the remembered path (R4). An all-zero window tells a true miss apart from a wrong firing. Runs of five or more zeros show whether window zeros are wrongly reused as a new trigger pair, and 0,1,0 prefixes show whether a 1 clears partial pair progress. A long random stream biased toward 0s is then compared on every clock against a counter-based reference model, with a reset issued in the middle of a window.

// File: rtl/zp_window_det.sv
module zp_window_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ONE0  = 3'd1,
    S_ARMED = 3'd2,
    S_W2_N  = 3'd3,
    S_W2_Y  = 3'd4,
    S_W3_N  = 3'd5,
    S_W3_Y  = 3'd6
  } state_t;

  state_t state, state_nx;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= state_nx;
  end

  always_comb begin
    state_nx = S_IDLE;
    unique case (state)
      S_IDLE:  state_nx = din ? S_IDLE : S_ONE0;
      S_ONE0:  state_nx = din ? S_IDLE : S_ARMED;
      S_ARMED: state_nx = din ? S_W2_Y : S_W2_N;
      S_W2_N:  state_nx = din ? S_W3_Y : S_W3_N;
      S_W2_Y:  state_nx = S_W3_Y;
      S_W3_N:  state_nx = S_IDLE;
      S_W3_Y:  state_nx = S_IDLE;
      default: state_nx = S_IDLE;
    endcase
  end

  assign hit = (state == S_W3_Y) || ((state == S_W3_N) && din);

endmodule

module zp_window_det_chk (
  input logic       clk,
  input logic       rst,
  input logic       din,
  input logic       hit,
  input logic [2:0] st
);

  logic [2:0] since_rst;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst)                 since_rst <= 3'd0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_NO_EARLY_HIT: assert property (@(posedge clk) disable iff (rst)
    hit |-> (since_rst >= 3'd4)); // R1

  AST_IDLE_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !hit); // R1

  AST_PAIR_BEFORE_HIT: assert property (@(posedge clk) disable iff (rst)
    (hit && since_rst >= 3'd4) |-> (!$past(din, 3) && !$past(din, 4))); // R2

  AST_WINDOW_HAS_ONE: assert property (@(posedge clk) disable iff (rst)
    (hit && since_rst >= 3'd4) |-> (din || $past(din, 1) || $past(din, 2))); // R4

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    hit |=> !hit); // R6

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (st == 3'd0)); // R1

endmodule

bind zp_window_det zp_window_det_chk u_chk (
  .clk(clk), .rst(rst), .din(din), .hit(hit), .st(state)
);

// File: tb/zp_window_det_bench.sv
`timescale 1ns/1ps
module zp_window_det_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int checks = 0;
  int errors = 0;

  int  m_zeros = 0;
  int  m_pos   = 0;
  bit  m_seen  = 1'b0;
  bit  m_valid = 1'b0;

  always #2.5 clk = ~clk;

  zp_window_det u_zp_window_det (.clk(clk), .rst(rst), .din(din), .hit(hit));

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: hit=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic xv, input logic rv, input string req);
    logic exp;
    @(negedge clk);
    din = xv;
    rst = rv;
    #1;
    exp = (m_pos == 3) ? (m_seen | xv) : 1'b0;
    if (m_valid && !rv) check(hit, exp, req);
    @(posedge clk);
    if (rv) begin
      m_zeros = 0; m_pos = 0; m_seen = 1'b0; m_valid = 1'b1;
    end else if (m_pos == 0) begin
      if (xv) m_zeros = 0;
      else if (m_zeros == 1) begin m_zeros = 0; m_pos = 1; m_seen = 1'b0; end
      else m_zeros = 1;
    end else begin
      m_seen = m_seen | xv;
      m_pos  = (m_pos == 3) ? 0 : m_pos + 1;
    end
  endtask

  task automatic run_bits(input string bits, input string req);
    for (int i = 0; i < bits.len(); i++) step(bits[i] == "1", 1'b0, req);
  endtask

  task automatic expect_now(input logic exp, input string req);
    @(negedge clk);
    #1;
    check(hit, exp, req);
  endtask

  task automatic do_reset();
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b1, "R1");
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: hit=%b expected=finish", hit);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string xs, zs;
    do_reset();
    din = 1'b1; rst = 1'b0;
    expect_now(1'b0, "R1");
    din = 1'b0;
    #0.5;
    check(hit, 1'b0, "R1");

    xs = "0100010010010010000000011";
    zs = "0000001000000100000000001";
    do_reset();
    for (int i = 0; i < xs.len(); i++) begin
      @(negedge clk);
      din = (xs[i] == "1");
      rst = 1'b0;
      #1;
      check(hit, zs[i] == "1", "R8");
      @(posedge clk);
    end

    do_reset();
    run_bits("00001", "R3");
    do_reset();
    run_bits("00010", "R4");
    do_reset();
    run_bits("00100", "R4");
    do_reset();
    run_bits("00000", "R5");
    do_reset();
    run_bits("0000000001", "R6");
    run_bits("00000001", "R6");
    do_reset();
    run_bits("0100101001", "R7");
    run_bits("1010100111", "R2");

    do_reset();
    run_bits("000", "R1");
    do_reset();
    run_bits("11", "R1");

    for (int n = 0; n < 3000; n++) begin
      if (n == 1500) do_reset();
      step(($urandom % 10) < 3, 1'b0, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule